// File: doc/BRIEF.md
# Packet Page Allocator with Queues

This block owns the buffer pages of a small Ethernet controller. A bitmask records which of the pages are taken. Three short queues hold page numbers: frames waiting to go out, frames already sent whose pages the host has not yet reclaimed, and frames received that the host has not yet consumed. The host drives the block through a 3-bit command code (the upper three bits of a command byte written to the controller), an acknowledge byte, a mask byte and a current-page selector held by the surrounding register file.

A transmit allocation that finds every page in use is not refused. The allocation result reads 0x80 and the request stays pending. The first later release of any page serves it in that same cycle. Receive traffic takes pages through a request/accept handshake, and transmission is modelled as a per-page handshake in which the line side signals that the head page has been sent.

The interrupt status byte is kept here. Its transmit-empty and transmit-done flags follow queue occupancy. Its receive and allocation flags follow the commands. A single level interrupt output combines the status byte with the mask byte.

Top module: `pktpage_mgr`

## Requirements
- R1: After reset no page is used, all queues are empty (done and receive head codes read 0x80), the allocation code reads 0x00, the status byte reads 0x04, the mask reads 0x00 and irq is low.
- R2: Command code 1 (cmd_op) clears status bit 3 (allocation done), sets the allocation code to 0x80 and then takes the lowest-numbered free page. On success the code becomes that page number and bit 3 is set, all in the same cycle.
- R3: If command 1 finds all pages used, the code stays 0x80 with bit 3 clear. The next release of a page (command 4, command 5 or an automatic release after sending) allocates in the same cycle, writes the page number to the code and sets bit 3.
- R4: Command 2 clears the page map and all three queues and sets the allocation code to 0x00.
- R5: A receive request is accepted (rx_ack) when a page is free and the receive queue is not full. The lowest free page is taken, pushed to the receive queue and status bit 0 is set. Otherwise rx_drop is given and no state changes.
- R6: Command 3 pops the receive queue. Command 4 first frees the page at the receive queue head, then pops. After either command, bit 0 is set if entries remain and cleared if the queue is empty. A pop of an empty queue changes no queue.
- R7: Command 5 frees the page given on cur_page. Command 6 appends cur_page to the transmit queue, and this is ignored when the queue already holds PAGES entries.
- R8: tx_valid is high only when tx_en is 1 and the transmit queue is non-empty. tx_page shows the queue head, in the order pages were queued. On tx_sent the head is popped. With auto_rel set, the page is freed; otherwise it is appended to the done queue, unless that queue is full.
- R9: Command 7 empties the transmit and done queues and leaves the page map untouched.
- R10: Status bit 2 is set in every cycle the transmit queue is empty, and bit 1 in every cycle the done queue is non-empty. Both stay set until acknowledged.
- R11: An acknowledge write clears the status bits selected by ack_byte AND 0xD6, so bits 0 and 3 are never cleared this way. If ack_byte bit 1 is set, the done queue is popped.
- R12: irq is high exactly when some status bit is also set in the mask written by mask_wr.
- R13: Only one event is served per cycle. cmd_wr has priority over ack_wr, which is then ignored. A cycle with cmd_wr or ack_wr forces tx_valid low and gives neither rx_ack nor rx_drop. A transmit handshake has priority over a receive request.
- R14: Command 0 changes nothing. The done and receive head codes read 0x80 when their queue is empty and the page number otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 3 | Command code, upper three bits of the command byte |
| cur_page | input | IW | Page selected by the host for commands 5 and 6 |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_byte | input | 8 | Acknowledge value |
| mask_wr | input | 1 | Mask write strobe |
| mask_byte | input | 8 | New interrupt mask |
| tx_en | input | 1 | Transmit enable |
| auto_rel | input | 1 | Free pages automatically after sending |
| rx_req | input | 1 | Receive side asks for a page |
| rx_ack | output | 1 | Receive request accepted this cycle |
| rx_drop | output | 1 | Receive request refused this cycle |
| rx_page | output | IW | Page given to the accepted receive request |
| tx_valid | output | 1 | A queued page may be sent |
| tx_page | output | IW | Page at the transmit queue head |
| tx_sent | input | 1 | Line side has sent tx_page |
| alloc_code | output | 8 | Allocation result, 0x80 while pending |
| done_code | output | 8 | Done queue head or 0x80 |
| rx_code | output | 8 | Receive queue head or 0x80 |
| page_used | output | PAGES | Page allocation bitmask |
| int_status | output | 8 | Interrupt status byte |
| int_mask | output | 8 | Interrupt mask byte |
| irq | output | 1 | Level interrupt |

## Verification
A wrong page map appears after one command, either in page_used or in the page picked by the next allocation or receive. A lost pending allocation shows as alloc_code stuck at 0x80 right after a release. Queue ordering faults appear at tx_page or at the head codes as soon as one pop has happened. Sticky-flag errors appear in int_status and irq in the cycle after a queue empties or fills, or after an acknowledge.

// File: rtl/pktpage_pkg.sv
package pktpage_pkg;

  localparam logic [7:0] NONE_CODE = 8'h80;
  localparam logic [7:0] ACK_CLR_MASK = 8'hD6;

  localparam int ST_RCV   = 0;
  localparam int ST_TXD   = 1;
  localparam int ST_TXE   = 2;
  localparam int ST_ALLOC = 3;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_TXALLOC = 3'd1,
    OP_MMURST  = 3'd2,
    OP_RXPOP   = 3'd3,
    OP_RXFREE  = 3'd4,
    OP_FREE    = 3'd5,
    OP_TXPUSH  = 3'd6,
    OP_TXCLR   = 3'd7
  } mmu_op_e;

  function automatic logic [7:0] bit_of(input int pos);
    return 8'(1) << pos;
  endfunction

endpackage

// File: rtl/pp_shiftq.sv
module pp_shiftq #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         nxt_empty
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [W-1:0]  slot_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else begin
      if (pop && cnt_q != '0) begin
        for (int i = 0; i < DEPTH - 1; i++) slot_d[i] = slot_q[i + 1];
        cnt_d = cnt_q - CW'(1);
      end
      if (push && cnt_d < CW'(DEPTH)) begin
        for (int i = 0; i < DEPTH; i++)
          if (CW'(i) == cnt_d) slot_d[i] = din;
        cnt_d = cnt_d + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign head      = slot_q[0];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign nxt_empty = (cnt_d == '0);

  // R7: a push onto a full queue leaves it full
  a_r7_push_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (full && head == $past(head)));

  // R6: a pop of an empty queue leaves it empty
  a_r6_pop_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);

endmodule

// File: rtl/pp_pagemap.sv
module pp_pagemap #(
  parameter int PAGES = 4,
  parameter int IW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rel_en,
  input  logic [IW-1:0]    rel_idx,
  input  logic             alloc_en,
  output logic [PAGES-1:0] used,
  output logic             full,
  output logic             alloc_ok,
  output logic [IW-1:0]    alloc_idx
);

  // {found, index} of the lowest clear bit
  function automatic logic [IW:0] lowest_free(input logic [PAGES-1:0] m);
    logic [IW:0] r;
    r = '0;
    for (int i = PAGES - 1; i >= 0; i--)
      if (!m[i]) r = {1'b1, IW'(i)};
    return r;
  endfunction

  logic [PAGES-1:0] used_q, after_rel, used_d;
  logic [IW:0]      pick;

  always_comb begin
    after_rel = used_q;
    if (rel_en) after_rel = used_q & ~(PAGES'(1) << rel_idx);
    pick      = lowest_free(after_rel);
    alloc_ok  = alloc_en & pick[IW];
    alloc_idx = pick[IW-1:0];
    used_d    = after_rel;
    if (alloc_ok) used_d = after_rel | (PAGES'(1) << alloc_idx);
    if (clr) used_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end

  assign used = used_q;
  assign full = &used_q;

  // R2: a granted page is marked used on the next cycle
  a_r2_grant_marks_page: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ok && !clr) |=> used_q[$past(alloc_idx)]);

  // R2: a grant never goes to a page still in use after the release
  a_r2_grant_was_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> !used_q[alloc_idx] || (rel_en && rel_idx == alloc_idx));

endmodule

// File: rtl/pp_intctl.sv
module pp_intctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] set_bits,
  input  logic [7:0] clr_bits,
  input  logic       txq_empty_nxt,
  input  logic       done_busy_nxt,
  input  logic       mask_we,
  input  logic [7:0] mask_wdata,
  output logic [7:0] status,
  output logic [7:0] mask,
  output logic       irq
);
  import pktpage_pkg::*;

  logic [7:0] st_q, st_d, mk_q;

  always_comb begin
    st_d = (st_q & ~clr_bits) | set_bits;
    if (txq_empty_nxt) st_d = st_d | bit_of(ST_TXE);
    if (done_busy_nxt) st_d = st_d | bit_of(ST_TXD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= bit_of(ST_TXE);
      mk_q <= '0;
    end else begin
      st_q <= st_d;
      if (mask_we) mk_q <= mask_wdata;
    end
  end

  assign status = st_q;
  assign mask   = mk_q;
  assign irq    = |(st_q & mk_q);

  // R12: a zero mask keeps the line low whatever the status
  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && mask_wdata == 8'h00) |=> !irq);

endmodule

// File: rtl/pktpage_mgr.sv
module pktpage_mgr #(
  parameter int PAGES = 4,
  localparam int IW = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [2:0]       cmd_op,
  input  logic [IW-1:0]    cur_page,
  input  logic             ack_wr,
  input  logic [7:0]       ack_byte,
  input  logic             mask_wr,
  input  logic [7:0]       mask_byte,
  input  logic             tx_en,
  input  logic             auto_rel,
  input  logic             rx_req,
  output logic             rx_ack,
  output logic             rx_drop,
  output logic [IW-1:0]    rx_page,
  output logic             tx_valid,
  output logic [IW-1:0]    tx_page,
  input  logic             tx_sent,
  output logic [7:0]       alloc_code,
  output logic [7:0]       done_code,
  output logic [7:0]       rx_code,
  output logic [PAGES-1:0] page_used,
  output logic [7:0]       int_status,
  output logic [7:0]       int_mask,
  output logic             irq
);
  import pktpage_pkg::*;

  function automatic logic [7:0] head_code(input logic is_empty, input logic [IW-1:0] h);
    return is_empty ? NONE_CODE : 8'(h);
  endfunction

  mmu_op_e op;
  logic host_busy, ev_cmd, ev_ack, ev_tx, ev_rx, rx_room;
  logic op_rst, op_txalloc, op_rxpop_any, op_txclr;
  logic pending, rel_en, alloc_en, alloc_ok;
  logic [IW-1:0] rel_idx, alloc_idx;
  logic map_full;
  logic [7:0] alloc_q, alloc_d, set_bits, clr_bits;

  logic txq_head_empty, txq_full, txq_nxt_empty;
  logic dq_empty, dq_full, dq_nxt_empty;
  logic rq_empty, rq_full, rq_nxt_empty;
  logic [IW-1:0] txq_head, dq_head, rq_head;

  // one event per cycle: command, then acknowledge, then send, then receive
  assign op        = mmu_op_e'(cmd_op);
  assign host_busy = cmd_wr | ack_wr;
  assign ev_cmd    = cmd_wr;
  assign ev_ack    = ack_wr & ~cmd_wr;
  assign tx_valid  = tx_en & ~txq_head_empty & ~host_busy;
  assign ev_tx     = tx_valid & tx_sent;
  assign ev_rx     = rx_req & ~host_busy & ~ev_tx;
  assign rx_room   = ~map_full & ~rq_full;
  assign rx_ack    = ev_rx & rx_room;
  assign rx_drop   = ev_rx & ~rx_room;

  assign op_rst       = ev_cmd && op == OP_MMURST;
  assign op_txalloc   = ev_cmd && op == OP_TXALLOC;
  assign op_rxpop_any = ev_cmd && (op == OP_RXPOP || op == OP_RXFREE);
  assign op_txclr     = ev_cmd && op == OP_TXCLR;
  assign pending      = (alloc_q == NONE_CODE);

  always_comb begin
    rel_en  = 1'b0;
    rel_idx = cur_page;
    if (ev_cmd && op == OP_FREE) begin
      rel_en  = 1'b1;
      rel_idx = cur_page;
    end else if (ev_cmd && op == OP_RXFREE && !rq_empty) begin
      rel_en  = 1'b1;
      rel_idx = rq_head;
    end else if (ev_tx && auto_rel) begin
      rel_en  = 1'b1;
      rel_idx = txq_head;
    end
  end

  assign alloc_en = op_txalloc | (rel_en & pending) | rx_ack;

  pp_pagemap #(.PAGES(PAGES), .IW(IW)) i_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (op_rst),
    .rel_en   (rel_en),
    .rel_idx  (rel_idx),
    .alloc_en (alloc_en),
    .used     (page_used),
    .full     (map_full),
    .alloc_ok (alloc_ok),
    .alloc_idx(alloc_idx)
  );

  assign rx_page = alloc_idx;

  always_comb begin
    alloc_d = alloc_q;
    if (op_rst)
      alloc_d = 8'h00;
    else if (op_txalloc)
      alloc_d = alloc_ok ? 8'(alloc_idx) : NONE_CODE;
    else if (rel_en && pending && alloc_ok)
      alloc_d = 8'(alloc_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) alloc_q <= 8'h00;
    else        alloc_q <= alloc_d;
  end

  assign alloc_code = alloc_q;

  pp_shiftq #(.DEPTH(PAGES), .W(IW)) i_txq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (op_rst | op_txclr),
    .push     (ev_cmd && op == OP_TXPUSH),
    .din      (cur_page),
    .pop      (ev_tx),
    .head     (txq_head),
    .empty    (txq_head_empty),
    .full     (txq_full),
    .nxt_empty(txq_nxt_empty)
  );

  pp_shiftq #(.DEPTH(PAGES), .W(IW)) i_doneq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (op_rst | op_txclr),
    .push     (ev_tx & ~auto_rel),
    .din      (txq_head),
    .pop      (ev_ack & ack_byte[ST_TXD]),
    .head     (dq_head),
    .empty    (dq_empty),
    .full     (dq_full),
    .nxt_empty(dq_nxt_empty)
  );

  pp_shiftq #(.DEPTH(PAGES), .W(IW)) i_rxq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (op_rst),
    .push     (rx_ack),
    .din      (alloc_idx),
    .pop      (op_rxpop_any),
    .head     (rq_head),
    .empty    (rq_empty),
    .full     (rq_full),
    .nxt_empty(rq_nxt_empty)
  );

  assign tx_page   = txq_head;
  assign done_code = head_code(dq_empty, dq_head);
  assign rx_code   = head_code(rq_empty, rq_head);

  always_comb begin
    set_bits = '0;
    clr_bits = '0;
    if (op_txalloc) clr_bits = clr_bits | bit_of(ST_ALLOC);
    if (alloc_ok && !rx_ack) set_bits = set_bits | bit_of(ST_ALLOC);
    if (rx_ack) set_bits = set_bits | bit_of(ST_RCV);
    if (op_rxpop_any) begin
      if (rq_nxt_empty) clr_bits = clr_bits | bit_of(ST_RCV);
      else              set_bits = set_bits | bit_of(ST_RCV);
    end
    if (ev_ack) clr_bits = clr_bits | (ack_byte & ACK_CLR_MASK);
  end

  pp_intctl i_int (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_bits     (set_bits),
    .clr_bits     (clr_bits),
    .txq_empty_nxt(txq_nxt_empty),
    .done_busy_nxt(~dq_nxt_empty),
    .mask_we      (mask_wr),
    .mask_wdata   (mask_byte),
    .status       (int_status),
    .mask         (int_mask),
    .irq          (irq)
  );

  // R10: transmit-empty flag present whenever the transmit queue is empty
  a_r10_txe_follows_queue: assert property (@(posedge clk) disable iff (!rst_n)
    txq_head_empty |-> int_status[ST_TXE]);

  // R10: transmit-done flag present whenever the done queue holds a page
  a_r10_txd_follows_queue: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_empty |-> int_status[ST_TXD]);

  // R3: allocating with every page used leaves the request pending
  a_r3_pending_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (op_txalloc && map_full) |=> (alloc_code == NONE_CODE && !int_status[ST_ALLOC]));

  // R4: allocator reset empties the map and the receive queue
  a_r4_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    op_rst |=> (page_used == '0 && alloc_code == 8'h00 && rx_code == NONE_CODE));

  // R5: a receive grant always names a page that was free
  a_r5_rx_page_free: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |-> !page_used[rx_page]);

  // R13: a host write cycle never answers the receive side
  a_r13_host_blocks_rx: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |-> !(rx_ack || rx_drop || tx_valid));

  // R8: with sending disabled the queue head is held
  a_r8_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !cmd_wr) |=> $stable(tx_page));

endmodule

// File: tb/test_pktpage_mgr.sv
`timescale 1ns/1ps
module test_pktpage_mgr;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 0, ack_wr = 0, mask_wr = 0, tx_en = 0, auto_rel = 0;
  logic rx_req = 0, tx_sent = 0;
  logic [2:0] cmd_op = 0;
  logic [1:0] cur_page = 0;
  logic [7:0] ack_byte = 0, mask_byte = 0;
  logic rx_ack, rx_drop, tx_valid, irq;
  logic [1:0] rx_page, tx_page;
  logic [7:0] alloc_code, done_code, rx_code, int_status, int_mask;
  logic [3:0] page_used;

  always #4 clk = ~clk;

  pktpage_mgr i_pktpage_mgr (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cur_page(cur_page),
    .ack_wr(ack_wr), .ack_byte(ack_byte), .mask_wr(mask_wr), .mask_byte(mask_byte),
    .tx_en(tx_en), .auto_rel(auto_rel), .rx_req(rx_req), .rx_ack(rx_ack),
    .rx_drop(rx_drop), .rx_page(rx_page), .tx_valid(tx_valid), .tx_page(tx_page),
    .tx_sent(tx_sent), .alloc_code(alloc_code), .done_code(done_code),
    .rx_code(rx_code), .page_used(page_used), .int_status(int_status),
    .int_mask(int_mask), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {
    string tag;
    int ares, dcode, rcode, st, mk, used, irq;
  } exp_t;
  exp_t expq[$];

  // reference model
  int m_used, m_ares, m_st, m_mk;
  int tq[$], dq[$], rq[$];

  function automatic int lowfree();
    for (int i = 0; i < 4; i++) if (((m_used >> i) & 1) == 0) return i;
    return -1;
  endfunction

  function automatic void m_fix();
    if (tq.size() == 0) m_st = m_st | 4;
    if (dq.size() > 0)  m_st = m_st | 2;
  endfunction

  function automatic void m_try();
    int f;
    f = lowfree();
    if (f >= 0) begin
      m_ares = f;
      m_used = m_used | (1 << f);
      m_st = m_st | 8;
    end
  endfunction

  function automatic void m_rel(int p);
    m_used = m_used & ~(1 << p);
    if (m_ares == 128) m_try();
  endfunction

  function automatic void m_rxpop();
    if (rq.size() > 0) void'(rq.pop_front());
    if (rq.size() > 0) m_st = m_st | 1;
    else m_st = m_st & ~1;
  endfunction

  function automatic void m_cmd(int c, int pg);
    case (c)
      1: begin m_ares = 128; m_st = m_st & ~8; m_try(); end
      2: begin m_used = 0; tq.delete(); dq.delete(); rq.delete(); m_ares = 0; end
      3: m_rxpop();
      4: begin if (rq.size() > 0) m_rel(rq[0]); m_rxpop(); end
      5: m_rel(pg);
      6: if (tq.size() < 4) tq.push_back(pg);
      7: begin tq.delete(); dq.delete(); end
      default: ;
    endcase
    m_fix();
  endfunction

  function automatic void push_exp(string tag);
    exp_t e;
    e.tag = tag;
    e.ares = m_ares;
    e.dcode = (dq.size() == 0) ? 128 : dq[0];
    e.rcode = (rq.size() == 0) ? 128 : rq[0];
    e.st = m_st;
    e.mk = m_mk;
    e.used = m_used;
    e.irq = ((m_st & m_mk) != 0) ? 1 : 0;
    expq.push_back(e);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares registered outputs one cycle after each driven event
  initial begin
    forever begin
      @(negedge clk);
      if (expq.size() > 0) begin
        exp_t e;
        int act_all, exp_all;
        e = expq.pop_front();
        act_all = {alloc_code, done_code, rx_code, int_status};
        exp_all = {e.ares[7:0], e.dcode[7:0], e.rcode[7:0], e.st[7:0]};
        chk(act_all == exp_all, {e.tag, " codes/status"}, act_all, exp_all);
        chk({int_mask, page_used, irq} == {e.mk[7:0], e.used[3:0], e.irq[0]},
            {e.tag, " mask/map/irq"}, {int_mask, page_used, irq},
            {e.mk[7:0], e.used[3:0], e.irq[0]});
      end
    end
  end

  // drivers: called at a falling edge, return at a falling edge
  task automatic do_cmd(int c, int pg, string tag);
    cmd_wr = 1; cmd_op = 3'(c); cur_page = 2'(pg);
    m_cmd(c, pg);
    @(posedge clk); push_exp(tag);
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic do_ack(int v, string tag);
    ack_wr = 1; ack_byte = 8'(v);
    m_st = m_st & ~(v & 'hD6);
    if ((v & 2) != 0 && dq.size() > 0) void'(dq.pop_front());
    m_fix();
    @(posedge clk); push_exp(tag);
    @(negedge clk); ack_wr = 0;
  endtask

  task automatic do_mask(int v, string tag);
    mask_wr = 1; mask_byte = 8'(v); m_mk = v;
    @(posedge clk); push_exp(tag);
    @(negedge clk); mask_wr = 0;
  endtask

  task automatic do_rx(string tag);
    bit room;
    int f;
    rx_req = 1;
    room = (m_used != 15) && (rq.size() < 4);
    f = lowfree();
    #1;
    chk(rx_ack == room && rx_drop == !room, {tag, " rx handshake"}, {rx_ack, rx_drop}, {room, !room});
    if (room) begin
      chk(rx_page == 2'(f), {tag, " rx page"}, rx_page, f);
      m_used = m_used | (1 << f); rq.push_back(f); m_st = m_st | 1; m_fix();
    end
    @(posedge clk); push_exp(tag);
    @(negedge clk); rx_req = 0;
  endtask

  task automatic do_tx(string tag);
    int p;
    tx_sent = 1;
    #1;
    chk(tx_valid == 1'b1 && tx_page == 2'(tq[0]), {tag, " tx head"}, {tx_valid, tx_page}, {1'b1, 2'(tq[0])});
    p = tq.pop_front();
    if (auto_rel) m_rel(p);
    else if (dq.size() < 4) dq.push_back(p);
    m_fix();
    @(posedge clk); push_exp(tag);
    @(negedge clk); tx_sent = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_used = 0; m_ares = 0; m_st = 4; m_mk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); push_exp("R1 reset state");
    @(negedge clk);

    do_mask('h0F, "R12 mask enables TX_EMPTY");
    do_cmd(0, 0, "R14 no-op command");
    for (int i = 0; i < 4; i++) do_cmd(1, 0, "R2 lowest free page");
    do_cmd(1, 0, "R3 all pages used gives 0x80");
    do_cmd(5, 2, "R3 release serves pending alloc");
    do_ack('hFF, "R11 ack keeps bits 0 and 3");
    do_cmd(6, 0, "R7 enqueue page");
    do_ack('h04, "R10 TX_EMPTY cleared while queue busy");
    #1 chk(tx_valid == 1'b0, "R8 tx_valid low when disabled", tx_valid, 0);
    do_cmd(6, 1, "R7 enqueue page");
    do_cmd(6, 2, "R7 enqueue page");
    do_cmd(6, 3, "R7 enqueue page");
    do_cmd(6, 1, "R7 enqueue on full ignored");
    tx_en = 1; auto_rel = 0;
    #1 chk(tx_valid == 1'b1, "R8 tx_valid with tx_en", tx_valid, 1);
    cmd_wr = 1; cmd_op = 0;
    #1 chk(tx_valid == 1'b0, "R13 host write blocks tx_valid", tx_valid, 0);
    @(posedge clk); push_exp("R13 no-op during tx");
    @(negedge clk); cmd_wr = 0;
    do_tx("R8 send in order");
    do_tx("R8 send in order");
    do_tx("R8 send in order");
    do_ack('h02, "R11 ack TX pops done queue");
    do_cmd(7, 0, "R9 clear transmit queues");
    tx_en = 0;
    do_cmd(2, 0, "R4 allocator reset");
    for (int i = 0; i < 4; i++) do_rx("R5 receive takes page");
    do_rx("R5 receive dropped when full");
    rx_req = 1; cmd_wr = 1; cmd_op = 0;
    #1 chk(rx_ack == 0 && rx_drop == 0, "R13 host write holds rx", {rx_ack, rx_drop}, 0);
    @(posedge clk); push_exp("R13 rx held");
    @(negedge clk); rx_req = 0; cmd_wr = 0;
    do_cmd(3, 0, "R6 pop keeps page");
    do_cmd(4, 0, "R6 pop with release");
    do_cmd(4, 0, "R6 pop with release");
    do_cmd(4, 0, "R6 last pop clears RCV");
    do_cmd(3, 0, "R6 pop of empty queue");
    do_cmd(2, 0, "R4 allocator reset");
    for (int i = 0; i < 4; i++) do_cmd(1, 0, "R2 allocate");
    do_cmd(1, 0, "R3 pending allocation");
    do_cmd(6, 1, "R7 enqueue page");
    tx_en = 1; auto_rel = 1;
    do_tx("R3 auto release serves pending alloc");
    cmd_wr = 1; cmd_op = 3'd5; cur_page = 0; ack_wr = 1; ack_byte = 8'hFF;
    m_cmd(5, 0);
    @(posedge clk); push_exp("R13 command wins over ack");
    @(negedge clk); cmd_wr = 0; ack_wr = 0;
    do_mask('h00, "R12 mask cleared drops irq");
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule